// File: doc/BRIEF.md
# Serial Converter Frame Interface Controller

This block is the digital side of a serial-output analog-to-digital converter, as the converter sees it. Two asynchronous host signals come in. One is an active-low select/frame strobe, `frame_n`. The other is the host's serial clock, `sck`. Both are brought into the system clock domain, and the block detects their edges there.

A falling strobe opens a frame. At that moment the block captures the conversion engine's latest 12-bit result, enables the serial output and presents the most significant bit. Later serial clock edges shift out the rest of a 16-bit word. The sample window opens on the fifth clock of the frame. At the end of the sixteenth clock the output is tri-stated, the window closes and the block pulses a conversion start.

The same strobe also moves a two-input channel selector when it rises. A frame that ran to completion and whose conversion finished advances the selector. A frame of only four to seven serial clocks returns it to channel 0. Any other frame leaves it unchanged.

The control is a four-state machine:
- `ST_IDLE`: the strobe is high.
- `ST_SHIFT`: the frame is active and bits are shifting.
- `ST_CONVERT`: sixteen clocks are done and the engine is busy.
- `ST_DONE`: the engine reported completion and the strobe is still low.

Its transitions:
- IDLE→SHIFT on a strobe fall.
- SHIFT→CONVERT on the falling edge of the sixteenth serial clock.
- CONVERT→DONE on `conv_done`.
- SHIFT, CONVERT or DONE → IDLE on a strobe rise.

Top module: `adc_frame_if`

## Requirements
- R1: Within three system clocks of a falling edge on `frame_n`, `sdo_oe` is 1 and `sdo` equals bit 11 of `result_in` as captured at that edge.
- R2: `result_in` is captured only at the frame-opening edge. Changing it during a frame has no effect on the bits shifted out in that frame.
- R3: The serial word has 16 bits, most significant first. Word bits 15..4 are result bits 11..0, in plain unsigned binary. Word bits 3..0 are 0. After serial rising edge k, `sdo` shows word bit 15 when k is 1, and word bit 16−k when k is 2 to 16. `sdo` changes only after a rising `sck` edge.
- R4: `sdo_oe` falls after the falling edge of the 16th serial clock. It also falls whenever `frame_n` rises, and it is 0 while `frame_n` is high. `sdo` reads 0 whenever `sdo_oe` is 0.
- R5: `sample_win` is 1 from the 5th rising `sck` edge of a frame through the 16th falling edge, which is 12 clocks, and 0 at all other times.
- R6: `conv_start` pulses for exactly one system clock after the 16th falling `sck` edge of a frame. There is no pulse for a frame with fewer than 16 clocks, and no pulse for extra clocks beyond 16.
- R7: When `frame_n` rises after a frame of 4 to 7 rising `sck` edges, `chan_sel` becomes 0 (channel 0).
- R8: When `frame_n` rises after a full 16-clock frame whose `conv_done` pulse has arrived, `chan_sel` toggles.
- R9: A strobe rise in any other case leaves `chan_sel` unchanged. This covers frames of 1 to 3 or 8 to 16 or more clocks whose conversion has not completed.
- R10: `sck` edges while `frame_n` is high are ignored. `sdo_oe` stays 0, and the next frame still starts its count at 1.
- R11: After reset, `sdo_oe`, `sdo`, `sample_win`, `conv_start` and `chan_sel` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_n | input | 1 | Asynchronous active-low select/frame strobe from the host |
| sck | input | 1 | Asynchronous serial clock from the host |
| result_in | input | 12 | Latest result from the conversion engine |
| conv_done | input | 1 | One-cycle pulse from the engine when a conversion finishes |
| sdo | output | 1 | Serial data bit (0 when disabled) |
| sdo_oe | output | 1 | Output enable for the three-state data pad |
| sample_win | output | 1 | Sample window flag for the input stage |
| conv_start | output | 1 | One-cycle conversion start request |
| chan_sel | output | 1 | Selected input channel (0 or 1) |

## Verification
Every host edge passes through two synchronizer flops and an edge register before the registered outputs react. So `sdo`, `sdo_oe`, `sample_win`, `conv_start` and `chan_sel` settle three system clocks after the host pin changes. The bench holds each host level for six system clocks and samples on the falling system clock edge. No check can land inside that three-cycle latency.

The one-cycle `conv_start` pulse is counted by an edge-triggered counter. That count is compared against the model at each strobe rise, so the exact cycle of the pulse does not matter to the check. Expected bits and the channel state come from bench functions built on the requirements.

// File: rtl/adc_frame_pkg.sv
package adc_frame_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SHIFT   = 2'd1,
        ST_CONVERT = 2'd2,
        ST_DONE    = 2'd3
    } frame_state_t;

endpackage

// File: rtl/adc_edge_sync.sv
module adc_edge_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= RST_VAL;
                else        sync_q <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= {STAGES{RST_VAL}};
                else        sync_q <= {sync_q[STAGES-2:0], din};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= RST_VAL;
        else        last_q <= sync_q[STAGES-1];
    end

    assign rise = sync_q[STAGES-1] & ~last_q;
    assign fall = ~sync_q[STAGES-1] & last_q;
endmodule

// File: rtl/adc_frame_fsm.sv
module adc_frame_fsm
    import adc_frame_pkg::*;
#(
    parameter int FRAME_LEN = 16,
    parameter int WIN_FIRST = 5,
    parameter int RST_MIN   = 4,
    parameter int RST_MAX   = 7,
    parameter int CNT_W     = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_fall,
    input  logic sel_rise,
    input  logic sck_rise,
    input  logic sck_fall,
    input  logic conv_done,
    output logic load,
    output logic shift,
    output logic oe,
    output logic win,
    output logic conv_start,
    output logic chan_adv,
    output logic chan_clr
);
    localparam logic [CNT_W-1:0] LEN_C  = CNT_W'(FRAME_LEN);
    localparam logic [CNT_W-1:0] WIN_C  = CNT_W'(WIN_FIRST);
    localparam logic [CNT_W-1:0] RMIN_C = CNT_W'(RST_MIN);
    localparam logic [CNT_W-1:0] RMAX_C = CNT_W'(RST_MAX);
    localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);

    frame_state_t     state_q, state_nx;
    logic [CNT_W-1:0] cnt_q, cnt_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_nx;
            cnt_q   <= cnt_nx;
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state_q;
        cnt_nx   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (sel_fall) begin
                    state_nx = ST_SHIFT;
                    cnt_nx   = '0;
                end
            end
            ST_SHIFT: begin
                if (sel_rise) begin
                    state_nx = ST_IDLE;
                end else begin
                    if (sck_rise && cnt_q < LEN_C) cnt_nx = cnt_q + ONE_C;
                    if (sck_fall && cnt_q == LEN_C) state_nx = ST_CONVERT;
                end
            end
            ST_CONVERT: begin
                if (sel_rise)       state_nx = ST_IDLE;
                else if (conv_done) state_nx = ST_DONE;
            end
            ST_DONE: begin
                if (sel_rise) state_nx = ST_IDLE;
            end
        endcase
    end

    // single-cycle controls for the datapath
    assign load     = (state_q == ST_IDLE) && sel_fall;
    assign shift    = (state_q == ST_SHIFT) && !sel_rise && sck_rise
                      && (cnt_q >= ONE_C) && (cnt_q < LEN_C);
    assign chan_adv = (state_q == ST_DONE) && sel_rise;
    assign chan_clr = (state_q == ST_SHIFT) && sel_rise
                      && (cnt_q >= RMIN_C) && (cnt_q <= RMAX_C);

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe         <= 1'b0;
            win        <= 1'b0;
            conv_start <= 1'b0;
        end else begin
            oe         <= (state_nx == ST_SHIFT);
            win        <= (state_nx == ST_SHIFT) && (cnt_nx >= WIN_C);
            conv_start <= (state_q == ST_SHIFT) && (state_nx == ST_CONVERT);
        end
    end
endmodule

// File: rtl/adc_out_shift.sv
module adc_out_shift #(
    parameter int RES_W     = 12,
    parameter int FRAME_LEN = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             shift,
    input  logic             oe,
    input  logic [RES_W-1:0] result,
    output logic             sdo
);
    localparam int PAD_W = FRAME_LEN - RES_W;

    logic [FRAME_LEN-1:0] word_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     word_q <= '0;
        else if (load)  word_q <= {result, {PAD_W{1'b0}}};
        else if (shift) word_q <= {word_q[FRAME_LEN-2:0], 1'b0};
    end

    assign sdo = oe & word_q[FRAME_LEN-1];
endmodule

// File: rtl/adc_chan_sel.sv
module adc_chan_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic clr,
    output logic chan
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   chan <= 1'b0;
        else if (clr) chan <= 1'b0;
        else if (adv) chan <= ~chan;
    end
endmodule

// File: rtl/adc_frame_if.sv
module adc_frame_if #(
    parameter int RES_W       = 12,
    parameter int FRAME_LEN   = 16,
    parameter int WIN_FIRST   = 5,
    parameter int RST_MIN     = 4,
    parameter int RST_MAX     = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_n,
    input  logic             sck,
    input  logic [RES_W-1:0] result_in,
    input  logic             conv_done,
    output logic             sdo,
    output logic             sdo_oe,
    output logic             sample_win,
    output logic             conv_start,
    output logic             chan_sel
);
    localparam int CNT_W = $clog2(FRAME_LEN + 1);

    logic sel_rise, sel_fall, sck_rise, sck_fall;
    logic load, shift, chan_adv, chan_clr;

    adc_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sel_sync (
        .clk(clk), .rst_n(rst_n), .din(frame_n), .rise(sel_rise), .fall(sel_fall)
    );

    adc_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck_sync (
        .clk(clk), .rst_n(rst_n), .din(sck), .rise(sck_rise), .fall(sck_fall)
    );

    adc_frame_fsm #(
        .FRAME_LEN(FRAME_LEN), .WIN_FIRST(WIN_FIRST),
        .RST_MIN(RST_MIN), .RST_MAX(RST_MAX), .CNT_W(CNT_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .sel_fall(sel_fall), .sel_rise(sel_rise),
        .sck_rise(sck_rise), .sck_fall(sck_fall),
        .conv_done(conv_done),
        .load(load), .shift(shift), .oe(sdo_oe), .win(sample_win),
        .conv_start(conv_start), .chan_adv(chan_adv), .chan_clr(chan_clr)
    );

    adc_out_shift #(.RES_W(RES_W), .FRAME_LEN(FRAME_LEN)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(load), .shift(shift),
        .oe(sdo_oe), .result(result_in), .sdo(sdo)
    );

    adc_chan_sel u_chan (
        .clk(clk), .rst_n(rst_n), .adv(chan_adv), .clr(chan_clr), .chan(chan_sel)
    );
endmodule

// File: rtl/adc_frame_chk.sv
module adc_frame_chk (
    input logic clk,
    input logic rst_n,
    input logic sel_fall,
    input logic sel_rise,
    input logic sck_rise,
    input logic sdo,
    input logic sdo_oe,
    input logic sample_win,
    input logic conv_start,
    input logic chan_sel
);
    a_r1_oe_opens_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe) |-> $past(sel_fall));

    a_r3_sdo_moves_on_sck: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_oe && $past(sdo_oe) && !$past(sck_rise)) |-> $stable(sdo));

    a_r4_oe_off_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        sel_rise |=> !sdo_oe);

    a_r4_sdo_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_oe |-> !sdo);

    a_r5_win_inside_frame: assert property (@(posedge clk) disable iff (!rst_n)
        sample_win |-> sdo_oe);

    a_r6_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    a_r6_start_ends_frame: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> (!sdo_oe && $past(sdo_oe)));

    a_r9_chan_moves_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(chan_sel) |-> $past(sel_rise));
endmodule

bind adc_frame_if adc_frame_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sel_fall(sel_fall), .sel_rise(sel_rise),
    .sck_rise(sck_rise), .sdo(sdo), .sdo_oe(sdo_oe), .sample_win(sample_win),
    .conv_start(conv_start), .chan_sel(chan_sel)
);

// File: tb/test_adc_frame_if.sv
module test_adc_frame_if;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1;
    logic        sck = 1'b0;
    logic [11:0] result_in = '0;
    logic        conv_done = 1'b0;
    logic        sdo, sdo_oe, sample_win, conv_start, chan_sel;

    int checks = 0;
    int errors = 0;
    int starts = 0;
    int exp_starts = 0;
    bit exp_chan = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    adc_frame_if i_adc_frame_if (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .sck(sck),
        .result_in(result_in), .conv_done(conv_done),
        .sdo(sdo), .sdo_oe(sdo_oe), .sample_win(sample_win),
        .conv_start(conv_start), .chan_sel(chan_sel)
    );

    always @(posedge clk) if (rst_n && conv_start) starts++;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (6) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic bit exp_bit(input logic [11:0] v, input int k);
        logic [15:0] w;
        w = {v, 4'b0000};
        return (k <= 1) ? w[15] : w[16 - k];
    endfunction

    function automatic bit exp_win(input int k, input bit after_fall);
        if (k > 16 || (k == 16 && after_fall)) return 1'b0;
        return (k >= 5);
    endfunction

    function automatic bit next_chan(input bit cur, input int n, input bit conv);
        if (n >= 16 && conv) return ~cur;
        if (n >= 4 && n <= 7) return 1'b0;
        return cur;
    endfunction

    task automatic run_frame(input logic [11:0] v, input int n, input bit conv, input bit disturb);
        @(negedge clk);
        result_in = v;
        frame_n   = 1'b0;
        settle();
        check("R1 oe at frame start", sdo_oe, 1);
        check("R1 msb at frame start", sdo, v[11]);
        if (disturb) result_in = ~v;
        for (int k = 1; k <= n; k++) begin
            sck = 1'b1;
            settle();
            if (k <= 16) begin
                check(disturb ? "R2 bit after mid-frame change" : "R3 bit after rise", sdo, exp_bit(v, k));
                check("R5 window after rise", sample_win, exp_win(k, 0));
            end else begin
                check("R6 no frame after 16", sdo_oe, 0);
            end
            sck = 1'b0;
            settle();
            if (k == 16) begin
                check("R4 oe off after 16th", sdo_oe, 0);
                check("R5 window closed", sample_win, 0);
            end
        end
        if (n >= 16) exp_starts++;
        if (conv && n >= 16) begin
            @(negedge clk) conv_done = 1'b1;
            @(negedge clk) conv_done = 1'b0;
            settle();
        end
        check("R6 start count", starts, exp_starts);
        frame_n = 1'b1;
        settle();
        check("R4 oe off when strobe high", sdo_oe, 0);
        check("R4 sdo zero when off", sdo, 0);
        exp_chan = next_chan(exp_chan, n, conv);
        if (n >= 16 && conv)        check("R8 channel toggle", chan_sel, exp_chan);
        else if (n >= 4 && n <= 7) check("R7 channel reset", chan_sel, exp_chan);
        else                        check("R9 channel held", chan_sel, exp_chan);
    endtask

    initial begin
        void'($urandom(32'h5EED_0A11));
        repeat (5) @(posedge clk);
        @(negedge clk);
        check("R11 reset oe", sdo_oe, 0);
        check("R11 reset sdo", sdo, 0);
        check("R11 reset window", sample_win, 0);
        check("R11 reset start", conv_start, 0);
        check("R11 reset chan", chan_sel, 0);
        rst_n = 1'b1;
        settle();

        run_frame(12'hA5C, 16, 1, 0);   // R8 toggle to 1
        run_frame(12'hFFF, 16, 1, 0);   // R8 back to 0, full scale
        run_frame(12'h000, 16, 1, 0);   // zero scale, toggle to 1
        run_frame(12'h3C7, 5, 0, 0);    // R7 reset to 0
        run_frame(12'h123, 16, 1, 0);   // toggle to 1
        run_frame(12'h456, 3, 0, 0);    // R9 too short, held
        run_frame(12'h789, 8, 0, 0);    // R9 just past reset range, held
        run_frame(12'h9AB, 16, 0, 0);   // R9 conversion not done, held
        run_frame(12'hC3A, 16, 1, 1);   // R2 mid-frame result change
        run_frame(12'h5A5, 18, 1, 0);   // R6 extra clocks ignored

        // R10: stray clocks while idle
        for (int i = 0; i < 3; i++) begin
            sck = 1'b1; settle();
            check("R10 idle clock ignored", sdo_oe, 0);
            sck = 1'b0; settle();
        end
        run_frame(12'hB2D, 7, 0, 0);    // R10 count restarts; R7 at upper bound
        run_frame(12'h2D4, 4, 0, 0);    // R7 lower bound

        for (int f = 0; f < 40; f++) begin
            run_frame(12'($urandom), int'($urandom_range(1, 18)),
                      bit'($urandom % 2), bit'($urandom % 4 == 0));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule